// File: doc/BRIEF.md
# Control-Word Steered Register and Memory Datapath

This block is a single-cycle datapath whose every action is chosen by a control word that arrives from outside. It has a file of eight 32-bit registers with two read ports, which feed operand buses A and B, and one write port, which takes result bus D. Bus A can be taken from an external address input instead of a register. Bus B can be taken from an external constant input instead of a register. A function unit applies an arithmetic, logic or one-bit shift operation to the two buses. A result selector chooses whether bus D carries the function unit output or the word read from an attached data memory.

The memory is word addressed. Its address is the low bits of bus A and its write data is bus B. Reads are combinational, so a load finishes in the same cycle as its register write. The caller supplies the control words one per cycle. Fetching, decoding and sequencing of instructions are outside this block. The parameter `MEM_AW` sets the memory depth. The default of 8 keeps elaboration small, and a value of 16 gives the full 64K-word memory. Buses A, B and D are brought out as ports so they can be observed.

Top module: `dpCore`

## Requirements
- R1: A synchronous active-high `rst` clears all eight registers to zero, and it takes priority over a register write in the same cycle.
- R2: `busA` equals register `srcASel` when `aFromAddr` is 0 and equals `addrIn` when it is 1. `busB` equals register `srcBSel` when `bFromConst` is 0 and equals `constIn` when it is 1.
- R3: When `regWrEn` is 1, `busD` is stored into register `dstSel` at the next rising edge and all other registers keep their values. When `regWrEn` is 0, no register changes.
- R4: When `dFromMem` is 1, `busD` carries the memory word at address `busA[MEM_AW-1:0]`. When it is 0, `busD` carries the function unit result.
- R5: When `memWrEn` is 1, `busB` is stored into the memory word at `busA[MEM_AW-1:0]` at the next rising edge, and the other words keep their values.
- R6: `funcSel` values 0, 1, 2 and 3 give pass A, pass B, A+B and A-B. The arithmetic wraps modulo 2^32.
- R7: `funcSel` values 4, 5, 6 and 7 give A AND B, A OR B, A XOR B and NOT B.
- R8: `funcSel` values 8, 9 and 10 shift B by one bit. Value 8 is a logical shift left, 9 a logical shift right and 10 an arithmetic shift right, so 0x80FF0001 becomes 0xC07F8000 under value 10. Values 11 to 15 give zero.
- R9: A register may be both source and destination in one cycle, and its old value is the one used. Likewise, a load and a store to the same word in one cycle return the old memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the registers |
| srcASel | input | 3 | Register index read onto bus A |
| srcBSel | input | 3 | Register index read onto bus B |
| dstSel | input | 3 | Register index written from bus D |
| aFromAddr | input | 1 | 1 takes bus A from addrIn |
| bFromConst | input | 1 | 1 takes bus B from constIn |
| funcSel | input | 4 | Function unit operation code |
| dFromMem | input | 1 | 1 takes bus D from memory read data |
| regWrEn | input | 1 | Register write enable |
| memWrEn | input | 1 | Memory write enable |
| addrIn | input | 32 | External address operand |
| constIn | input | 32 | External constant operand |
| busA | output | 32 | Observed bus A |
| busB | output | 32 | Observed bus B |
| busD | output | 32 | Observed bus D |

## Verification
In one cycle, a memory store and a register write whose data comes from the same memory word can both take effect. The bench provokes this with one control word that stores a constant to an external address and also loads that address into a register. It passes only if the register receives the old word and the memory afterwards holds the new constant. The same question of ordering arises when one register is both read and written in a cycle. The bench judges this by doubling a register into itself and reading back twice the earlier value.

// File: rtl/dpPkg.sv
package dpPkg;
  typedef enum logic [3:0] {
    FN_PASSA = 4'd0,
    FN_PASSB = 4'd1,
    FN_ADD   = 4'd2,
    FN_SUB   = 4'd3,
    FN_AND   = 4'd4,
    FN_OR    = 4'd5,
    FN_XOR   = 4'd6,
    FN_NOTB  = 4'd7,
    FN_LSL   = 4'd8,
    FN_LSR   = 4'd9,
    FN_ASR   = 4'd10
  } funcE;

  typedef struct packed {
    logic aFromAddr;
    logic bFromConst;
    logic dFromMem;
    logic regWr;
    logic memWr;
    funcE func;
  } strobeT;
endpackage

// File: rtl/cwDecode.sv
module cwDecode
  import dpPkg::*;
(
  input  logic       aFromAddr,
  input  logic       bFromConst,
  input  logic [3:0] funcSel,
  input  logic       dFromMem,
  input  logic       regWrEn,
  input  logic       memWrEn,
  output strobeT     strobes
);
  always_comb begin
    strobes.aFromAddr  = aFromAddr;
    strobes.bFromConst = bFromConst;
    strobes.dFromMem   = dFromMem;
    strobes.regWr      = regWrEn;
    strobes.memWr      = memWrEn;
    strobes.func       = funcE'(funcSel);
  end
endmodule

// File: rtl/regFile.sv
module regFile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  rdASel,
  input  logic [SEL_W-1:0]  rdBSel,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdA,
  output logic [DATA_W-1:0] rdB
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wrEn) begin
      regs[wrSel] <= wrData;
    end
  end

  assign rdA = regs[rdASel];
  assign rdB = regs[rdBSel];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gChk
    // R1: registers are zero just after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> regs[g] == '0);
    // R3: a selected register captures the write data
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
      (wrEn && wrSel == SEL_W'(g)) |=> regs[g] == $past(wrData));
    // R3: an unselected register holds its value
    a_r3_others_hold: assert property (@(posedge clk) disable iff (rst)
      !(wrEn && wrSel == SEL_W'(g)) |=> $stable(regs[g]));
  end
endmodule

// File: rtl/funcUnit.sv
module funcUnit
  import dpPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  funcE              op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (op)
      FN_PASSA: res = opA;
      FN_PASSB: res = opB;
      FN_ADD:   res = opA + opB;
      FN_SUB:   res = opA + (~opB + DATA_W'(1));
      FN_AND:   res = opA & opB;
      FN_OR:    res = opA | opB;
      FN_XOR:   res = opA ^ opB;
      FN_NOTB:  res = ~opB;
      FN_LSL:   res = {opB[DATA_W-2:0], 1'b0};
      FN_LSR:   res = {1'b0, opB[DATA_W-1:1]};
      FN_ASR:   res = {opB[DATA_W-1], opB[DATA_W-1:1]};
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/dataMem.sv
module dataMem #(
  parameter int DATA_W = 32,
  parameter int MEM_AW = 8,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic [MEM_AW-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] words [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) words[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wrEn) words[addr] <= wrData;
  end

  assign rdData = words[addr];

  // R5: a store is visible at its address on the following cycle
  a_r5_store_lands: assert property (@(posedge clk)
    wrEn |=> words[$past(addr)] == $past(wrData));
endmodule

// File: rtl/dpPath.sv
module dpPath
  import dpPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int MEM_AW   = 8,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strobes,
  input  logic [SEL_W-1:0]  srcASel,
  input  logic [SEL_W-1:0]  srcBSel,
  input  logic [SEL_W-1:0]  dstSel,
  input  logic [DATA_W-1:0] addrIn,
  input  logic [DATA_W-1:0] constIn,
  output logic [DATA_W-1:0] busA,
  output logic [DATA_W-1:0] busB,
  output logic [DATA_W-1:0] busD
);
  logic [DATA_W-1:0] regA, regB, fuRes, memRd;

  regFile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) rf_i (
    .clk(clk), .rst(rst), .rdASel(srcASel), .rdBSel(srcBSel),
    .wrSel(dstSel), .wrEn(strobes.regWr), .wrData(busD),
    .rdA(regA), .rdB(regB)
  );

  assign busA = strobes.aFromAddr  ? addrIn  : regA;
  assign busB = strobes.bFromConst ? constIn : regB;

  funcUnit #(.DATA_W(DATA_W)) fu_i (
    .op(strobes.func), .opA(busA), .opB(busB), .res(fuRes)
  );

  dataMem #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) mem_i (
    .clk(clk), .addr(busA[MEM_AW-1:0]), .wrEn(strobes.memWr),
    .wrData(busB), .rdData(memRd)
  );

  assign busD = strobes.dFromMem ? memRd : fuRes;

  // R6: subtraction is undone by adding B back
  a_r6_sub_inverse: assert property (@(posedge clk) disable iff (rst)
    (!strobes.dFromMem && strobes.func == FN_SUB) |-> busD + busB == busA);
  // R7: inversion leaves no bit shared with B
  a_r7_not_compl: assert property (@(posedge clk) disable iff (rst)
    (!strobes.dFromMem && strobes.func == FN_NOTB) |-> (busD ^ busB) == '1);
  // R8: arithmetic right shift keeps the sign bit
  a_r8_asr_sign: assert property (@(posedge clk) disable iff (rst)
    (!strobes.dFromMem && strobes.func == FN_ASR) |-> busD[DATA_W-1] == busB[DATA_W-1]);
  // R8: left shift puts zero in bit 0
  a_r8_lsl_fill: assert property (@(posedge clk) disable iff (rst)
    (!strobes.dFromMem && strobes.func == FN_LSL) |-> busD[0] == 1'b0);
endmodule

// File: rtl/dpCore.sv
module dpCore
  import dpPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int MEM_AW   = 8,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  srcASel,
  input  logic [SEL_W-1:0]  srcBSel,
  input  logic [SEL_W-1:0]  dstSel,
  input  logic              aFromAddr,
  input  logic              bFromConst,
  input  logic [3:0]        funcSel,
  input  logic              dFromMem,
  input  logic              regWrEn,
  input  logic              memWrEn,
  input  logic [DATA_W-1:0] addrIn,
  input  logic [DATA_W-1:0] constIn,
  output logic [DATA_W-1:0] busA,
  output logic [DATA_W-1:0] busB,
  output logic [DATA_W-1:0] busD
);
  strobeT strobes;

  cwDecode dec_i (
    .aFromAddr(aFromAddr), .bFromConst(bFromConst), .funcSel(funcSel),
    .dFromMem(dFromMem), .regWrEn(regWrEn), .memWrEn(memWrEn),
    .strobes(strobes)
  );

  dpPath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .MEM_AW(MEM_AW)) path_i (
    .clk(clk), .rst(rst), .strobes(strobes), .srcASel(srcASel),
    .srcBSel(srcBSel), .dstSel(dstSel), .addrIn(addrIn), .constIn(constIn),
    .busA(busA), .busB(busB), .busD(busD)
  );
endmodule

// File: tb/dpCore_tb.sv
module dpCore_tb_top;
  logic        clk = 0;
  logic        rst;
  logic [2:0]  srcASel, srcBSel, dstSel;
  logic        aFromAddr, bFromConst, dFromMem, regWrEn, memWrEn;
  logic [3:0]  funcSel;
  logic [31:0] addrIn, constIn, busA, busB, busD;
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  dpCore dut_i (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    srcASel = 0; srcBSel = 0; dstSel = 0; aFromAddr = 0; bFromConst = 0;
    dFromMem = 0; regWrEn = 0; memWrEn = 0; funcSel = 0; addrIn = 0; constIn = 0;
  endtask

  // one control word applied for one clock edge
  task automatic cw(input logic [2:0] a, input logic [2:0] b, input logic [2:0] d,
                    input logic aa, input logic bc, input logic [3:0] f,
                    input logic dm, input logic rw, input logic mw,
                    input logic [31:0] ad, input logic [31:0] k);
    srcASel = a; srcBSel = b; dstSel = d; aFromAddr = aa; bFromConst = bc;
    funcSel = f; dFromMem = dm; regWrEn = rw; memWrEn = mw; addrIn = ad; constIn = k;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic readReg(input logic [2:0] i, output logic [31:0] v);
    idle(); srcASel = i; #1; v = busA;
  endtask

  task automatic readMem(input logic [31:0] ad, output logic [31:0] v);
    idle(); aFromAddr = 1; addrIn = ad; dFromMem = 1; #1; v = busD;
    idle();
  endtask

  task automatic fuCase(input string tag, input logic [3:0] f, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] exp);
    idle(); aFromAddr = 1; bFromConst = 1; addrIn = a; constIn = b; funcSel = f; #1;
    check(tag, busD, exp);
    idle();
  endtask

  task automatic tReset();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      readReg(3'(i), v); check("R1 reset clears", v, 0);
    end
  endtask

  task automatic tOperands();
    idle(); aFromAddr = 1; addrIn = 32'hDEAD0001; bFromConst = 1; constIn = 32'h0BAD0002; #1;
    check("R2 busA from addrIn", busA, 32'hDEAD0001);
    check("R2 busB from constIn", busB, 32'h0BAD0002);
    idle();
  endtask

  task automatic tFunctions();
    fuCase("R6 pass A", 0, 32'h1234_5678, 32'h5, 32'h1234_5678);
    fuCase("R6 pass B", 1, 32'h1234_5678, 32'h5, 32'h5);
    fuCase("R6 add", 2, 3, 5, 8);
    fuCase("R6 sub", 3, 3, 5, 32'hFFFF_FFFE);
    fuCase("R6 add wraps", 2, 32'hFFFF_FFFF, 2, 1);
    fuCase("R7 and", 4, 32'hF0F0_00FF, 32'h0F0F_0F0F, 32'h0000_000F);
    fuCase("R7 or", 5, 32'hF0F0_00FF, 32'h0F0F_0F0F, 32'hFFFF_0FFF);
    fuCase("R7 xor", 6, 32'hF0F0_00FF, 32'h0F0F_0F0F, 32'hFFFF_0FF0);
    fuCase("R7 not B", 7, 7, 32'h80FF_0001, 32'h7F00_FFFE);
    fuCase("R8 lsl", 8, 7, 32'h80FF_0001, 32'h01FE_0002);
    fuCase("R8 lsr", 9, 7, 32'h80FF_0001, 32'h407F_8000);
    fuCase("R8 asr", 10, 7, 32'h80FF_0001, 32'hC07F_8000);
    fuCase("R8 unused code", 12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
  endtask

  task automatic tSequence();
    logic [31:0] v;
    cw(0, 0, 1, 0, 1, 1, 0, 1, 0, 0, 5);               // R1 <- 5
    cw(1, 1, 2, 0, 0, 2, 0, 1, 0, 0, 0);               // R2 <- R1 + R1
    cw(0, 0, 3, 0, 1, 1, 0, 1, 0, 0, 32'h1234_5678);   // R3 <- const
    cw(3, 0, 3, 0, 1, 4, 0, 1, 0, 0, 32'h0F0F_0F0F);   // R3 <- R3 & mask
    cw(0, 3, 4, 0, 0, 10, 0, 1, 0, 0, 0);              // R4 <- asr R3
    cw(2, 2, 2, 0, 0, 2, 0, 1, 0, 0, 0);               // R2 <- R2 + R2
    cw(1, 1, 5, 0, 0, 2, 0, 0, 0, 0, 0);               // no write
    readReg(1, v); check("R3 load constant", v, 5);
    readReg(2, v); check("R9 same reg source and dest", v, 20);
    readReg(3, v); check("R3 mask result", v, 32'h0204_0608);
    readReg(4, v); check("R3 shift result", v, 32'h0102_0304);
    readReg(5, v); check("R3 write disabled", v, 0);
  endtask

  task automatic tMemory();
    logic [31:0] v;
    cw(1, 2, 0, 0, 0, 0, 0, 0, 1, 0, 0);               // M[R1] <- R2
    readMem(5, v); check("R5 store lands", v, 20);
    readMem(4, v); check("R5 neighbour untouched", v, 0);
    cw(1, 0, 6, 0, 0, 0, 1, 1, 0, 0, 0);               // R6 <- M[R1]
    readReg(6, v); check("R4 load into register", v, 20);
    cw(0, 0, 7, 1, 1, 0, 1, 1, 1, 9, 32'h18);          // M[9] <- 0x18, R7 <- M[9]
    readReg(7, v); check("R9 load sees old word", v, 0);
    readMem(9, v); check("R9 store in same cycle", v, 32'h18);
  endtask

  task automatic tResetPriority();
    logic [31:0] v;
    rst = 1;
    cw(0, 0, 1, 0, 1, 1, 0, 1, 0, 0, 32'h77);
    rst = 0;
    readReg(1, v); check("R1 reset beats write", v, 0);
    readReg(2, v); check("R1 reset clears R2", v, 0);
  endtask

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    tReset();
    tOperands();
    tFunctions();
    tSequence();
    tMemory();
    tResetPriority();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule